// File: doc/BRIEF.md
# Asynchronous EPROM Read Interface

This block lets a synchronous host read 16-bit words from an asynchronous EPROM. The device has separate active-low chip-enable and output-enable pins. The host raises a request with an 18-bit word address and holds it until it sees a one-cycle acknowledge. The block then drives the address and pulls chip-enable low. It pulls output-enable low a set number of cycles later. Once both the address-access delay and the output-enable delay have been counted out in clock cycles, it captures the data. The captured word comes back on a read-data bus, marked by a one-cycle valid strobe.

At the capture edge both enables return high, which puts the device back into standby with its outputs high-impedance. The device's drivers need time to float after that. The block therefore counts a float-recovery interval before it accepts another request, so no other driver is turned on while the device still drives the bus.

All delays are parameters in clock cycles. With the default values, OE is delayed 10 cycles after the address, and the access still completes in the plain 23-cycle address-access time.

Top module: `eprom_read_bridge`

## Requirements
- R1: While reset is low and after it, with no request, the chip-enable and output-enable outputs are high, and ack, rvalid and rdata are zero.
- R2: A request seen while idle is acknowledged by a one-cycle ack. In that same cycle chip-enable is low and the memory address equals the request address. No further ack occurs during the access.
- R3: The memory address stays fixed for the whole chip-enable low window, whatever the host address input does.
- R4: Output-enable goes low exactly OE_LAG cycles after chip-enable goes low and stays low to the end of the window. It is never low while chip-enable is high.
- R5: Chip-enable stays low for exactly CAP cycles, where CAP is the larger of ACC_CYC and OE_LAG+OE_CYC. The data input is sampled at the clock edge that ends the window. rvalid is high in the following cycle, and rdata then holds the sampled word.
- R6: Chip-enable and output-enable rise together at the capture edge.
- R7: After the capture edge, chip-enable stays high for FLOAT_CYC+1 cycles before the next access begins. A request that is pending during that time gets no ack until the interval has ended. It is acknowledged in the first cycle after.
- R8: rvalid lasts exactly one cycle. rdata keeps the captured word until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host read request, held until ack |
| addr_i | input | 18 | Host word address |
| ack_o | output | 1 | One-cycle request acknowledge |
| rdata_o | output | 16 | Captured read data |
| rvalid_o | output | 1 | One-cycle strobe, rdata_o is new |
| mem_addr_o | output | 18 | Address to the EPROM |
| mem_ce_no | output | 1 | EPROM chip enable, active low |
| mem_oe_no | output | 1 | EPROM output enable, active low |
| mem_data_i | input | 16 | Data from the EPROM |

## Verification
The bench drives reads from a table of addresses, including all-zero, all-one and alternating bit patterns. Each table entry has a different idle gap before its request. Some gaps make the request land inside the float interval and some land after it, which separates a correct recovery count from an early or late acceptance. The memory model returns the inverted pattern until both counted delays have elapsed. A capture taken one cycle early therefore yields wrong data, as does a missing OE delay. A back-to-back request raised in the very cycle of the valid strobe checks the float hold-off. A reset in the middle of an access shows that both enables drop back to standby at once.

// File: rtl/erb_pkg.sv
package erb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACCESS,
    ST_FLOAT
  } erb_state_e;

  function automatic int unsigned larger(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Cycles chip-enable is held low: the slower of the address path and the
  // delayed output-enable path decides.
  function automatic int unsigned capture_cycles(input int unsigned acc,
                                                 input int unsigned lag,
                                                 input int unsigned oe);
    return larger(acc, lag + oe);
  endfunction

  function automatic int unsigned count_width(input int unsigned top);
    return (top < 2) ? 1 : $clog2(top + 1);
  endfunction

endpackage

// File: rtl/erb_counter.sv
module erb_counter #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (en_i)  q_o <= q_o + W'(1);
  end

endmodule

// File: rtl/erb_ctrl.sv
module erb_ctrl
  import erb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned ACC_CYC   = 23,
  parameter int unsigned OE_CYC    = 13,
  parameter int unsigned OE_LAG    = 10,
  parameter int unsigned FLOAT_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ce_n_o,
  output logic              oe_n_o,
  output logic              ack_o,
  output logic              cap_fire_o
);

  localparam int unsigned CAP   = capture_cycles(ACC_CYC, OE_LAG, OE_CYC);
  localparam int unsigned CNT_W = count_width(larger(CAP, FLOAT_CYC));
  localparam logic [CNT_W-1:0] CAP_LAST   = CNT_W'(CAP - 1);
  localparam logic [CNT_W-1:0] FLOAT_LAST = CNT_W'(FLOAT_CYC - 1);

  erb_state_e       state_q, state_d;
  logic [CNT_W-1:0] acc_q, flt_q;
  logic             accept, oe_start, cap_fire, flt_done;

  // Named events
  assign accept   = (state_q == ST_IDLE) && req_i;
  assign cap_fire = (state_q == ST_ACCESS) && (acc_q == CAP_LAST);
  assign flt_done = (state_q == ST_FLOAT) && (flt_q == FLOAT_LAST);
  assign cap_fire_o = cap_fire;

  erb_counter #(.W(CNT_W)) u_acc_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept),
    .en_i  (state_q == ST_ACCESS),
    .q_o   (acc_q)
  );

  erb_counter #(.W(CNT_W)) u_flt_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cap_fire),
    .en_i  (state_q == ST_FLOAT),
    .q_o   (flt_q)
  );

  generate
    if (OE_LAG == 0) begin : g_oe_with_ce
      assign oe_start = accept;
    end else begin : g_oe_delayed
      localparam logic [CNT_W-1:0] LAG_LAST = CNT_W'(OE_LAG - 1);
      assign oe_start = (state_q == ST_ACCESS) && (acc_q == LAG_LAST);
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept)   state_d = ST_ACCESS;
      ST_ACCESS: if (cap_fire) state_d = ST_FLOAT;
      ST_FLOAT:  if (flt_done) state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ce_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
      ack_o   <= 1'b0;
      addr_o  <= '0;
    end else begin
      state_q <= state_d;
      ack_o   <= accept;
      if (accept) begin
        addr_o <= addr_i;
        ce_n_o <= 1'b0;
      end else if (cap_fire) begin
        ce_n_o <= 1'b1;
      end
      if (cap_fire)      oe_n_o <= 1'b1;
      else if (oe_start) oe_n_o <= 1'b0;
    end
  end

  // R4: output enable only inside the chip-enable window
  assert_oe_inside_ce_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_o |-> !ce_n_o);

  // R2: acknowledge coincides with the start of the access
  assert_ack_with_ce_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (!ce_n_o && $fell(ce_n_o)));

endmodule

// File: rtl/erb_capture.sv
module erb_capture #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= cap_i;
      if (cap_i) rdata_o <= data_i;
    end
  end

  // R8: strobe lasts one cycle
  assert_valid_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  // R8: data held between strobes
  assert_rdata_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> $stable(rdata_o));

endmodule

// File: rtl/eprom_read_bridge.sv
module eprom_read_bridge
  import erb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ACC_CYC   = 23,
  parameter int unsigned OE_CYC    = 13,
  parameter int unsigned OE_LAG    = 10,
  parameter int unsigned FLOAT_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  input  logic [DATA_W-1:0] mem_data_i
);

  localparam int unsigned CAP   = capture_cycles(ACC_CYC, OE_LAG, OE_CYC);
  localparam int unsigned RUN_W = 16;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic cap_fire;

  erb_ctrl #(
    .ADDR_W   (ADDR_W),
    .ACC_CYC  (ACC_CYC),
    .OE_CYC   (OE_CYC),
    .OE_LAG   (OE_LAG),
    .FLOAT_CYC(FLOAT_CYC)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .addr_i    (addr_i),
    .addr_o    (mem_addr_o),
    .ce_n_o    (mem_ce_no),
    .oe_n_o    (mem_oe_no),
    .ack_o     (ack_o),
    .cap_fire_o(cap_fire)
  );

  erb_capture #(.DATA_W(DATA_W)) u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap_fire),
    .data_i  (mem_data_i),
    .rdata_o (rdata_o),
    .rvalid_o(rvalid_o)
  );

  // Pin-level run counters observed by the timing assertions
  logic [RUN_W-1:0] ce_lo_run, oe_lo_run, ce_hi_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_lo_run <= '0;
      oe_lo_run <= '0;
      ce_hi_run <= RUN_W'(FLOAT_CYC + 1);
    end else begin
      ce_lo_run <= mem_ce_no ? '0 : ((ce_lo_run == RUN_MAX) ? ce_lo_run : ce_lo_run + RUN_W'(1));
      oe_lo_run <= mem_oe_no ? '0 : ((oe_lo_run == RUN_MAX) ? oe_lo_run : oe_lo_run + RUN_W'(1));
      ce_hi_run <= !mem_ce_no ? '0 : ((ce_hi_run == RUN_MAX) ? ce_hi_run : ce_hi_run + RUN_W'(1));
    end
  end

  // R5: chip-enable window length
  assert_ce_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_ce_no) |-> (ce_lo_run == RUN_W'(CAP)));

  // R4: output-enable window length
  assert_oe_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_oe_no) |-> (oe_lo_run == RUN_W'(CAP - OE_LAG)));

  // R7: float recovery before the next access
  assert_float_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_no) |-> (ce_hi_run >= RUN_W'(FLOAT_CYC + 1)));

  // R3: address frozen during the window
  assert_addr_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> $stable(mem_addr_o));

  // R6: both enables release together
  assert_release_together_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_ce_no) |-> $rose(mem_oe_no));

endmodule

// File: tb/eprom_read_bridge_test.sv
`timescale 1ns/1ps
module eprom_read_bridge_test;

  localparam int ACC = 23;
  localparam int OE  = 13;
  localparam int LAG = 10;
  localparam int FLT = 8;
  localparam int WIN = (LAG + OE > ACC) ? LAG + OE : ACC;
  localparam int NV  = 6;

  typedef struct packed {
    logic [17:0] addr;
    logic [7:0]  gap;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{18'h00000, 8'd0},
    '{18'h3FFFF, 8'd0},
    '{18'h2AAAA, 8'd3},
    '{18'h15555, 8'd7},
    '{18'h00001, 8'd12},
    '{18'h20000, 8'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [17:0] addr_in = '0;
  logic        ack;
  logic [15:0] rdata;
  logic        rvalid;
  logic [17:0] mem_addr;
  logic        ce_n, oe_n;
  logic [15:0] mem_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int ce_t = 0;
  int oe_t = 0;

  always #2 clk = ~clk;

  eprom_read_bridge #(
    .ADDR_W(18), .DATA_W(16), .ACC_CYC(ACC), .OE_CYC(OE),
    .OE_LAG(LAG), .FLOAT_CYC(FLT)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr_in),
    .ack_o(ack), .rdata_o(rdata), .rvalid_o(rvalid),
    .mem_addr_o(mem_addr), .mem_ce_no(ce_n), .mem_oe_no(oe_n),
    .mem_data_i(mem_data)
  );

  function automatic logic [15:0] pat(input logic [17:0] a);
    return a[15:0] ^ {a[17:16], a[17:16], 12'hC35};
  endfunction

  // Memory model: correct word only once both delays have fully elapsed
  always @(posedge clk) begin
    ce_t <= ce_n ? 0 : ce_t + 1;
    oe_t <= oe_n ? 0 : oe_t + 1;
  end
  assign mem_data = (!ce_n && !oe_n && (ce_t + 1 >= ACC) && (oe_t + 1 >= OE))
                    ? pat(mem_addr) : ~pat(mem_addr);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a negedge where req has just been raised
  task automatic run_read(input logic [17:0] a, input int expw);
    int  w;
    int  n;
    int  oe_first;
    bit  got;
    bit  done;
    bit  bad_addr;
    bit  extra_ack;
    bit  early_ce;
    bit  early_valid;
    w = 0; got = 0; early_ce = 0; early_valid = 0;
    while (!got && w < 500) begin
      @(negedge clk);
      w++;
      if (rvalid) early_valid = 1;
      if (ack) got = 1;
      else if (!ce_n) early_ce = 1;
    end
    chk("R7 cycles until ack", w, expw);
    chk("R7 CE stays high before ack", early_ce, 0);
    chk("R8 rvalid low while waiting", early_valid, 0);
    chk("R2 CE low with ack", ce_n, 0);
    chk("R2 address driven with ack", mem_addr, a);
    req = 1'b0;
    addr_in = ~a;
    n = 1;
    oe_first = (oe_n == 1'b0) ? 1 : 0;
    done = 0; bad_addr = 0; extra_ack = 0;
    while (!done) begin
      @(negedge clk);
      if (ce_n) done = 1;
      else begin
        n++;
        if (mem_addr !== a) bad_addr = 1;
        if (ack) extra_ack = 1;
        if (!oe_n && oe_first == 0) oe_first = n;
        if (n > 1000) done = 1;
      end
    end
    chk("R5 CE low cycles", n, WIN);
    chk("R4 OE low after lag", oe_first, LAG + 1);
    chk("R3 address held", bad_addr, 0);
    chk("R2 single ack", extra_ack, 0);
    chk("R6 OE released with CE", oe_n, 1);
    chk("R5 rvalid after window", rvalid, 1);
    chk("R5 captured word", rdata, pat(a));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 CE in reset", ce_n, 1);
    chk("R1 OE in reset", oe_n, 1);
    chk("R1 ack in reset", ack, 0);
    chk("R1 rvalid in reset", rvalid, 0);
    chk("R1 rdata in reset", rdata, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 CE idle without request", ce_n, 1);
    chk("R1 OE idle without request", oe_n, 1);

    // Vector table: addresses with varying idle gaps
    for (int i = 0; i < NV; i++) begin
      int j;
      int expw;
      if (i > 0) repeat (VECS[i].gap) @(negedge clk);
      j = 1 + int'(VECS[i].gap);
      expw = (i == 0) ? 1 : ((FLT + 1 > j + 1) ? FLT + 1 - j : 1);
      req = 1'b1;
      addr_in = VECS[i].addr;
      run_read(VECS[i].addr, expw);
      @(negedge clk);
      chk("R8 rvalid single cycle", rvalid, 0);
      chk("R8 rdata held", rdata, pat(VECS[i].addr));
    end

    // Back-to-back: request raised in the strobe cycle, must wait out float
    repeat (12) @(negedge clk);
    req = 1'b1; addr_in = 18'h0F0F0;
    run_read(18'h0F0F0, 1);
    req = 1'b1; addr_in = 18'h30303;
    run_read(18'h30303, FLT + 1);
    @(negedge clk);
    chk("R8 rdata after back-to-back", rdata, pat(18'h30303));

    // Reset in the middle of an access
    repeat (12) @(negedge clk);
    req = 1'b1; addr_in = 18'h12345;
    @(negedge clk);
    req = 1'b0;
    repeat (14) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 CE released by reset", ce_n, 1);
    chk("R1 OE released by reset", oe_n, 1);
    chk("R1 rvalid cleared by reset", rvalid, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    req = 1'b1; addr_in = 18'h0ABCD;
    run_read(18'h0ABCD, 1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule